// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the strobe timing for one parallel ATA channel that serves two drive units, for PIO and multiword DMA transfers. Software programs a timing byte per unit (an encoded active count in the upper nibble and an encoded recovery count in the lower nibble) and an address setup code. A cycle request names the unit and the direction. The block then holds the address phase for the setup time, asserts the read or write strobe for the active time, and keeps the strobe low for the recovery time. It returns to idle with a one-clock done pulse.

Two variants exist, chosen by the `SHARED_SETUP` parameter. The primary-channel variant (`SHARED_SETUP=0`) keeps one setup register per unit, and every cycle uses the slower of the two. The secondary-channel variant (`SHARED_SETUP=1`, the default) keeps a single setup register. That register also carries an interrupt flag, and setup writes must not disturb it. Counts are taken from the registers at the moment a request is accepted and held for the rest of that cycle.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset the block is idle with done, addr_en, rd_stb, wr_stb and irq_flag low. Every timing register holds the slowest setting: a timing byte of 0x00 gives 16 active and 16 recovery clocks, and a setup code of 2'b11 gives 5 setup clocks.
- R2: An accepted request gives, in order: addr_en high with no strobe for the setup count, a strobe for the active count, and addr_en high with no strobe for the recovery count. The next clock is idle with done high for exactly one clock.
- R3: The active count comes from bits 7:4 of the selected unit's timing byte. Field values 1 to 15 give that many clocks, and 0 gives 16.
- R4: The recovery count comes from bits 3:0 of the selected unit's timing byte. Field value 0 gives 16 clocks, values 1 to 14 give the field value plus one, and 15 gives 1 clock.
- R5: The setup code sits in bits 7:6 of a setup register write. Code 2'b01 gives 2 clocks, 2'b10 gives 3, 2'b00 gives 4 and 2'b11 gives 5.
- R6: cfg_addr 0 writes unit 0's timing byte and cfg_addr 1 writes unit 1's. A cycle uses the timing byte of req_unit.
- R7: With SHARED_SETUP=0, cfg_addr 2 and 3 write the setup codes of unit 0 and unit 1. Every cycle, for either unit, uses the larger of the two setup counts.
- R8: With SHARED_SETUP=1, cfg_addr 2 writes the single setup code used by both units, and writes to cfg_addr 3 have no effect.
- R9: With SHARED_SETUP=1, irq_flag is set by irq_evt. It is cleared by a write to cfg_addr 2 with bit 4 set, and left unchanged by a write to cfg_addr 2 with bit 4 clear. With SHARED_SETUP=0, irq_flag stays low.
- R10: A request is accepted only while idle. A request made during a cycle is ignored and starts no later cycle.
- R11: Timing and setup values are captured when a request is accepted. A register write during a cycle does not change that cycle, and it applies to the next one.
- R12: req_write=0 gives rd_stb and req_write=1 gives wr_stb during the active phase. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0/1 unit timing, 2/3 setup |
| cfg_wdata | input | 8 | Register write data |
| irq_evt | input | 1 | Sets the interrupt flag (shared variant) |
| req | input | 1 | Cycle request, taken while idle |
| req_unit | input | 1 | Unit served by the requested cycle |
| req_write | input | 1 | Direction: 1 write strobe, 0 read strobe |
| done | output | 1 | One-clock pulse after the recovery phase |
| addr_en | output | 1 | Address phase active (setup through recovery) |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| irq_flag | output | 1 | Interrupt flag held in the shared setup register |

## Verification
Two situations are hard to reach from the ports alone. The first is the choice of the larger setup across units on the primary variant, which must hold while the other unit's setup is the larger one. The second is the capture of counts at acceptance, which can only be seen when a register changes partway through a live cycle. The bench drives a shared-setup instance and a primary instance in lockstep from the same inputs, so each cfg_addr 3 write tests the max selection on one instance and the ignored write on the other. It sweeps all sixteen setup-code pairs. Timing-register writes and a second request are injected a few clocks into a running cycle, and each cycle's measured phase lengths are then compared against the values captured at acceptance.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

    localparam int CNT_W      = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_UNITS  = 2;
    localparam int ADDR_W     = 2;
    localparam int ACT_LSB    = 4;
    localparam int REC_LSB    = 0;
    localparam int FLD_W      = 4;
    localparam int SU_LSB     = 6;
    localparam int SU_W       = 2;
    localparam int FLAG_BIT   = 4;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [FLD_W-1:0] fld_t;
    typedef logic [SU_W-1:0]  su_code_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t active;
        cnt_t recov;
    } cyc_cfg_t;

    localparam cnt_t FULL_CNT = cnt_t'(16);

    function automatic cnt_t active_clocks(input fld_t f);
        return (f == '0) ? FULL_CNT : cnt_t'(f);
    endfunction

    function automatic cnt_t recov_clocks(input fld_t f);
        cnt_t r;
        if (f == '0)
            r = FULL_CNT;
        else if (f == '1)
            r = cnt_t'(1);
        else
            r = cnt_t'(f) + cnt_t'(1);
        return r;
    endfunction

    function automatic cnt_t setup_clocks(input su_code_t c);
        cnt_t r;
        unique case (c)
            2'b01:   r = cnt_t'(2);
            2'b10:   r = cnt_t'(3);
            2'b00:   r = cnt_t'(4);
            default: r = cnt_t'(5);
        endcase
        return r;
    endfunction

    function automatic cnt_t max_cnt(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ata_tim_regs.sv
module ata_tim_regs
    import ata_tim_pkg::*;
#(
    parameter bit SHARED_SETUP = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic                                  irq_evt,
    output logic [NUM_UNITS-1:0][DATA_W-1:0]      tim_o,
    output logic [NUM_UNITS-1:0][SU_W-1:0]        su_code_o,
    output logic                                  flag_o
);

    localparam su_code_t SU_SLOWEST = 2'b11;
    localparam int       SU_BASE    = NUM_UNITS;

    logic [NUM_UNITS-1:0][DATA_W-1:0] tim_q;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[u] <= '0;
            else if (we && addr == ADDR_W'(u))
                tim_q[u] <= wdata;
        end
    end

    assign tim_o = tim_q;

    if (SHARED_SETUP) begin : g_shared
        su_code_t su_q;
        logic     flag_q;
        logic     hit;

        assign hit = we && (addr == ADDR_W'(SU_BASE));

        always_ff @(posedge clk) begin
            if (rst)
                su_q <= SU_SLOWEST;
            else if (hit)
                su_q <= wdata[SU_LSB +: SU_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (irq_evt)
                flag_q <= 1'b1;
            else if (hit && wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end

        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_fan
            assign su_code_o[u] = su_q;
        end
        assign flag_o = flag_q;
    end else begin : g_split
        su_code_t su_q [NUM_UNITS];
        logic     unused_evt;

        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_su
            always_ff @(posedge clk) begin
                if (rst)
                    su_q[u] <= SU_SLOWEST;
                else if (we && addr == ADDR_W'(SU_BASE + u))
                    su_q[u] <= wdata[SU_LSB +: SU_W];
            end
            assign su_code_o[u] = su_q[u];
        end

        assign unused_evt = irq_evt;
        assign flag_o     = 1'b0;
    end

endmodule

// File: rtl/ata_tim_decode.sv
module ata_tim_decode
    import ata_tim_pkg::*;
(
    input  logic [NUM_UNITS-1:0][DATA_W-1:0] tim_i,
    input  logic [NUM_UNITS-1:0][SU_W-1:0]   su_code_i,
    input  logic                             unit,
    output cyc_cfg_t                         cfg_o
);

    logic [DATA_W-1:0] sel_byte;
    cnt_t              su_clk [NUM_UNITS];
    cnt_t              su_max;

    assign sel_byte = tim_i[unit];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_su
        assign su_clk[u] = setup_clocks(su_code_i[u]);
    end

    // Slowest setup of both units; the shared variant feeds identical codes.
    assign su_max = max_cnt(su_clk[0], su_clk[1]);

    always_comb begin
        cfg_o.setup  = su_max;
        cfg_o.active = active_clocks(sel_byte[ACT_LSB +: FLD_W]);
        cfg_o.recov  = recov_clocks(sel_byte[REC_LSB +: FLD_W]);
    end

endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
    import ata_tim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     write,
    input  cyc_cfg_t cfg_i,
    output logic     done,
    output logic     addr_en,
    output logic     rd_stb,
    output logic     wr_stb
);

    phase_e ph_q;
    cnt_t   cnt_q;
    cnt_t   act_q;
    cnt_t   rec_q;
    logic   wr_q;
    logic   done_q;
    logic   last;

    assign last = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            act_q  <= '0;
            rec_q  <= '0;
            wr_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (req) begin
                        ph_q  <= PH_SETUP;
                        cnt_q <= cfg_i.setup - cnt_t'(1);
                        act_q <= cfg_i.active;
                        rec_q <= cfg_i.recov;
                        wr_q  <= write;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph_q  <= PH_ACTIVE;
                        cnt_q <= act_q - cnt_t'(1);
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (last) begin
                        ph_q  <= PH_RECOV;
                        cnt_q <= rec_q - cnt_t'(1);
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                PH_RECOV: begin
                    if (last) begin
                        ph_q   <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - cnt_t'(1);
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign addr_en = (ph_q != PH_IDLE);
    assign rd_stb  = (ph_q == PH_ACTIVE) && !wr_q;
    assign wr_stb  = (ph_q == PH_ACTIVE) &&  wr_q;

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
    import ata_tim_pkg::*;
#(
    parameter bit SHARED_SETUP = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                irq_evt,
    input  logic                req,
    input  logic                req_unit,
    input  logic                req_write,
    output logic                done,
    output logic                addr_en,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic                irq_flag
);

    logic [NUM_UNITS-1:0][DATA_W-1:0] tim;
    logic [NUM_UNITS-1:0][SU_W-1:0]   su_code;
    cyc_cfg_t                         cyc_cfg;

    ata_tim_regs #(.SHARED_SETUP(SHARED_SETUP)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .irq_evt   (irq_evt),
        .tim_o     (tim),
        .su_code_o (su_code),
        .flag_o    (irq_flag)
    );

    ata_tim_decode u_dec (
        .tim_i     (tim),
        .su_code_i (su_code),
        .unit      (req_unit),
        .cfg_o     (cyc_cfg)
    );

    ata_tim_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .write   (req_write),
        .cfg_i   (cyc_cfg),
        .done    (done),
        .addr_en (addr_en),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb)
    );

endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
    parameter bit SHARED_SETUP = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic req,
    input logic irq_evt,
    input logic done,
    input logic addr_en,
    input logic rd_stb,
    input logic wr_stb,
    input logic irq_flag
);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    assert_strobe_in_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> addr_en);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_recov_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(addr_en) && !$past(rd_stb) && !$past(wr_stb) && !addr_en));

    assert_start_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_en) |-> $past(req));

    assert_idle_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (req && !addr_en) |=> addr_en);

    if (SHARED_SETUP) begin : g_sh
        assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
            irq_evt |=> irq_flag);
    end else begin : g_pr
        assert_flag_low_R9: assert property (@(posedge clk) disable iff (rst)
            irq_evt |=> !irq_flag);
    end

endmodule

bind ata_pio_timer ata_pio_timer_chk #(.SHARED_SETUP(SHARED_SETUP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .irq_evt  (irq_evt),
    .done     (done),
    .addr_en  (addr_en),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .irq_flag (irq_flag)
);

// File: tb/ata_pio_timer_tb.sv
`timescale 1ns/1ps
module ata_pio_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       irq_evt = 1'b0;
    logic       req = 1'b0;
    logic       req_unit = 1'b0;
    logic       req_write = 1'b0;

    logic done_s, ae_s, rd_s, wr_s, fl_s;
    logic done_p, ae_p, rd_p, wr_p, fl_p;

    int vectors = 0;
    int miscomp = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ata_pio_timer #(.SHARED_SETUP(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_evt(irq_evt), .req(req),
        .req_unit(req_unit), .req_write(req_write), .done(done_s),
        .addr_en(ae_s), .rd_stb(rd_s), .wr_stb(wr_s), .irq_flag(fl_s)
    );

    ata_pio_timer #(.SHARED_SETUP(1'b0)) u_dut_p (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_evt(irq_evt), .req(req),
        .req_unit(req_unit), .req_write(req_write), .done(done_p),
        .addr_en(ae_p), .rd_stb(rd_p), .wr_stb(wr_p), .irq_flag(fl_p)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_act(input logic [3:0] f);
        return (f == 0) ? 16 : int'(f);
    endfunction

    function automatic int exp_rec(input logic [3:0] f);
        if (f == 0) return 16;
        if (f == 15) return 1;
        return int'(f) + 1;
    endfunction

    function automatic int exp_su(input logic [1:0] c);
        case (c)
            2'b01:   return 2;
            2'b10:   return 3;
            2'b00:   return 4;
            default: return 5;
        endcase
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Index 0: shared-setup instance, index 1: primary instance.
    task automatic run_cycle(input bit unit, input bit wr, input int es0, input int es1,
                             input int ea, input int er, input bit mreq, input bit mwr,
                             input string tag);
        int  s [2];
        int  a [2];
        int  r [2];
        int  bad [2];
        bit  seen [2];
        bit  fin [2];
        int  k;
        int  es [2];
        logic [1:0] ae, rd, ws, dn;
        es[0] = es0; es[1] = es1;
        for (int d = 0; d < 2; d++) begin
            s[d] = 0; a[d] = 0; r[d] = 0; bad[d] = 0; seen[d] = 0; fin[d] = 0;
        end
        req = 1'b1; req_unit = unit; req_write = wr;
        @(negedge clk);
        req = 1'b0;
        k = 0;
        while (!(fin[0] && fin[1]) && k < 200) begin
            ae = {ae_p, ae_s}; rd = {rd_p, rd_s}; ws = {wr_p, wr_s}; dn = {done_p, done_s};
            for (int d = 0; d < 2; d++) begin
                if (!fin[d]) begin
                    if (dn[d]) fin[d] = 1'b1;
                    else if (rd[d] || ws[d]) begin
                        a[d]++; seen[d] = 1'b1;
                        if (wr ? rd[d] : ws[d]) bad[d]++;
                    end else if (ae[d]) begin
                        if (seen[d]) r[d]++; else s[d]++;
                    end
                end
            end
            if (mwr && k == 2) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 8'h11; end
            if (mwr && k == 3) cfg_we = 1'b0;
            if (mreq && k == 3) begin req = 1'b1; req_unit = 1'b1; end
            if (mreq && k == 4) req = 1'b0;
            k++;
            @(negedge clk);
        end
        for (int d = 0; d < 2; d++) begin
            chk(fin[d] == 1'b1, $sformatf("%s inst%0d R2 done seen", tag, d), fin[d], 1);
            chk(s[d] == es[d], $sformatf("%s inst%0d setup clocks", tag, d), s[d], es[d]);
            chk(a[d] == ea, $sformatf("%s inst%0d active clocks", tag, d), a[d], ea);
            chk(r[d] == er, $sformatf("%s inst%0d recovery clocks", tag, d), r[d], er);
            chk(bad[d] == 0, $sformatf("%s inst%0d R12 wrong strobe", tag, d), bad[d], 0);
        end
        if (mreq) begin
            for (int j = 0; j < 2; j++) begin
                chk(!ae_s && !ae_p, $sformatf("%s R10 no restart", tag), int'(ae_s | ae_p), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!ae_s && !ae_p, "R1 addr_en idle", int'(ae_s | ae_p), 0);
        chk(!rd_s && !wr_s && !rd_p && !wr_p, "R1 strobes idle", int'(rd_s|wr_s|rd_p|wr_p), 0);
        chk(!done_s && !done_p, "R1 done low", int'(done_s | done_p), 0);
        chk(!fl_s && !fl_p, "R1 flag low", int'(fl_s | fl_p), 0);
        run_cycle(1'b0, 1'b0, 5, 5, 16, 16, 1'b0, 1'b0, "R1 slowest unit0");
        run_cycle(1'b1, 1'b1, 5, 5, 16, 16, 1'b0, 1'b0, "R1 slowest unit1");

        // R3 R4 R12: every timing byte on unit 0
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            cfg_write(2'd0, b);
            run_cycle(1'b0, b[0], 5, 5, exp_act(b[7:4]), exp_rec(b[3:0]), 1'b0, 1'b0,
                      $sformatf("R3/R4 byte %0h", v));
        end

        // R6: per-unit selection
        cfg_write(2'd0, 8'h9F);
        cfg_write(2'd1, 8'h35);
        run_cycle(1'b1, 1'b0, 5, 5, 3, 6, 1'b0, 1'b0, "R6 unit1");
        run_cycle(1'b0, 1'b1, 5, 5, 9, 1, 1'b0, 1'b0, "R6 unit0");

        // R5 R7 R8: all setup code pairs
        cfg_write(2'd0, 8'h11);
        for (int c0 = 0; c0 < 4; c0++) begin
            for (int c1 = 0; c1 < 4; c1++) begin
                int e0, e1;
                e0 = exp_su(2'(c0));
                e1 = exp_su(2'(c1));
                cfg_write(2'd2, {2'(c0), 6'h00});
                cfg_write(2'd3, {2'(c1), 6'h00});
                run_cycle(1'b0, 1'b0, e0, (e0 > e1) ? e0 : e1, 1, 2, 1'b0, 1'b0,
                          $sformatf("R5/R7/R8 codes %0d,%0d", c0, c1));
            end
        end

        // R9: interrupt flag in the shared setup register
        cfg_write(2'd3, 8'h00);
        cfg_write(2'd0, 8'h23);
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
        chk(fl_s == 1'b1, "R9 flag set shared", int'(fl_s), 1);
        chk(fl_p == 1'b0, "R9 flag low primary", int'(fl_p), 0);
        cfg_write(2'd2, 8'h40);
        chk(fl_s == 1'b1, "R9 flag kept on setup write", int'(fl_s), 1);
        run_cycle(1'b0, 1'b0, 2, 4, 2, 4, 1'b0, 1'b0, "R9 setup took");
        cfg_write(2'd2, 8'h50);
        chk(fl_s == 1'b0, "R9 flag cleared by bit4", int'(fl_s), 0);

        // R10: request during a cycle is ignored
        cfg_write(2'd2, 8'h80);
        cfg_write(2'd3, 8'h80);
        cfg_write(2'd0, 8'h88);
        run_cycle(1'b0, 1'b1, 3, 3, 8, 9, 1'b1, 1'b0, "R10 busy request");

        // R11: write during a cycle applies to the next cycle only
        run_cycle(1'b0, 1'b0, 3, 3, 8, 9, 1'b0, 1'b1, "R11 mid write");
        run_cycle(1'b0, 1'b0, 3, 3, 1, 2, 1'b0, 1'b0, "R11 next cycle");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule